// File: doc/BRIEF.md
# Memory-to-Stream DMA Channel (Single Transfer)

This block moves a contiguous run of bytes from memory onto a streaming output. Software programs it through four word-wide registers: control, status, source address and length. It fetches one data word at a time over a request/acknowledge memory read port. Each word goes out as one beat of a valid/ready stream. The beat that holds the final byte carries a last marker, and a byte-keep mask flags the valid bytes of a partial final word.

A transfer begins only when the length register is written. The other registers can be written in any order before that. The length write starts a transfer only if the channel is idle, the run bit is set and the length is nonzero. An invalid length write raises an error flag instead, and a length write while a transfer is running is dropped. Clearing the run bit in the middle of a transfer stops the channel once the beat in flight has been accepted. Completion and error flags are sticky. Either one can drive the interrupt output when its enable bit is set.

The stream side follows the usual back-pressure rules. A beat is transferred on a clock edge where `m_tvalid` and `m_tready` are both high. Once `m_tvalid` is raised it stays high, and data, keep and last hold their values, until the beat is taken. The block never waits on `m_tready` before raising `m_tvalid`.

Top module: `mm2s_dma_chan`

## Requirements
- R1: The register select codes are 0 for control, 1 for status, 2 for source address and 3 for length. Control bit 0 is run, bit 1 enables the completion interrupt and bit 2 enables the error interrupt. Control, source and length read back the values last written to them.
- R2: A length write with run=1 and a nonzero length while idle starts a transfer. The channel then requests the words at the source address rounded down to a multiple of 4, then at +4, +8 and so on, for ceil(length/4) words. While it requests memory it reports busy.
- R3: Each beat carries one memory word unchanged (byte 0 in bits 7:0). `m_tkeep` is 4'b1111 on every beat except a final beat carrying r<4 bytes, where it is the low r bits set (1→0001, 2→0011, 3→0111). `m_tlast` is high only on the final beat.
- R4: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata`, `m_tkeep` and `m_tlast` do not change on the next cycle.
- R5: Status bit 0 is idle, bit 1 halted, bit 2 completion and bit 3 error. Reset gives status 4'b0001. Accepting the last beat sets completion and idle in the same edge. Writing 1 to status bit 2 or bit 3 clears that flag.
- R6: A length write while idle with run=0 or with a length of zero starts no transfer (no memory request, no beat) and sets the error flag.
- R7: `irq` equals (completion AND its enable) OR (error AND its enable).
- R8: If run is 0 when a non-final beat is accepted, the channel goes idle with no further beats and without a last marker, and sets the halted flag. The next started transfer clears the halted flag.
- R9: A length write while a transfer is in progress changes neither the length register nor the transfer in flight, and sets no error.
- R10: `mem_req` stays high with `mem_addr` unchanged until a cycle with `mem_ack` high. The word on `mem_rdata` in that cycle is the one taken. The block never requests memory while a beat is pending on the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select for writes |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_sel | input | 2 | Register select for reads |
| reg_rd_data | output | 32 | Read data for the selected register (combinational) |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Word-aligned byte address of the request |
| mem_ack | input | 1 | Memory response; qualifies `mem_rdata` |
| mem_rdata | input | 32 | Memory read data |
| m_tvalid | output | 1 | Stream beat valid |
| m_tready | input | 1 | Stream sink ready |
| m_tdata | output | 32 | Stream data |
| m_tkeep | output | 4 | Valid-byte mask |
| m_tlast | output | 1 | Final beat of the transfer |

## Verification
The stream and memory-port properties assume only that reset is held for at least one clock. They allow `m_tready` and `mem_ack` to take any value in any cycle, including `mem_ack` pulses while no request is pending, which the channel must ignore. The stimulus drives both inputs at random from a fixed seed and also runs stretches with the sink always ready, so that long transfers and the halt point are reached quickly. Register writes are spaced one at a time, including the length writes issued deliberately while busy, while stopped and with a zero value.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {ENG_IDLE, ENG_FETCH, ENG_SEND} eng_state_t;

  localparam logic [1:0] RSEL_CTRL = 2'd0;
  localparam logic [1:0] RSEL_STAT = 2'd1;
  localparam logic [1:0] RSEL_SRC  = 2'd2;
  localparam logic [1:0] RSEL_LEN  = 2'd3;

  localparam int CB_RUN    = 0;
  localparam int CB_IOC_IE = 1;
  localparam int CB_ERR_IE = 2;

  localparam int SB_IDLE = 0;
  localparam int SB_HALT = 1;
  localparam int SB_IOC  = 2;
  localparam int SB_ERR  = 3;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_sel,
  output logic [DW-1:0] rd_data,
  input  logic          eng_busy,
  input  logic          eng_done,
  input  logic          eng_halt,
  output logic          run_o,
  output logic          start_o,
  output logic [AW-1:0] src_o,
  output logic [LW-1:0] start_len_o,
  output logic          irq_o
);
  logic [2:0]    ctrl_q;
  logic [AW-1:0] src_q;
  logic [LW-1:0] len_q;
  logic          halt_q, ioc_q, err_q;
  logic          len_wr;

  assign len_wr      = wr_en && (wr_sel == RSEL_LEN);
  assign start_len_o = wr_data[LW-1:0];
  assign start_o     = len_wr && !eng_busy && ctrl_q[CB_RUN] && (start_len_o != '0);
  assign run_o       = ctrl_q[CB_RUN];
  assign src_o       = src_q;
  assign irq_o       = (ioc_q && ctrl_q[CB_IOC_IE]) || (err_q && ctrl_q[CB_ERR_IE]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      src_q  <= '0;
      len_q  <= '0;
      halt_q <= 1'b0;
      ioc_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (wr_en && wr_sel == RSEL_CTRL) ctrl_q <= wr_data[2:0];
      if (wr_en && wr_sel == RSEL_SRC)  src_q  <= wr_data[AW-1:0];
      if (wr_en && wr_sel == RSEL_STAT) begin
        if (wr_data[SB_IOC]) ioc_q <= 1'b0;
        if (wr_data[SB_ERR]) err_q <= 1'b0;
      end
      if (eng_done) ioc_q  <= 1'b1;
      if (eng_halt) halt_q <= 1'b1;
      if (len_wr && !eng_busy) begin
        len_q <= start_len_o;
        if (start_o) halt_q <= 1'b0;
        else         err_q  <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      RSEL_CTRL: rd_data[2:0] = ctrl_q;
      RSEL_STAT: begin
        rd_data[SB_IDLE] = !eng_busy;
        rd_data[SB_HALT] = halt_q;
        rd_data[SB_IOC]  = ioc_q;
        rd_data[SB_ERR]  = err_q;
      end
      RSEL_SRC:  rd_data[AW-1:0] = src_q;
      default:   rd_data[LW-1:0] = len_q;
    endcase
  end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   src,
  input  logic [LW-1:0]   len,
  input  logic            run,
  output logic            busy,
  output logic            done,
  output logic            halt,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  input  logic            mem_ack,
  input  logic [DW-1:0]   mem_rdata,
  output logic            tvalid,
  input  logic            tready,
  output logic [DW-1:0]   tdata,
  output logic [DW/8-1:0] tkeep,
  output logic            tlast
);
  localparam int BPB = DW / 8;

  eng_state_t    state_q;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] rem_q;
  logic [DW-1:0] data_q;
  logic          beat_ok;

  assign busy     = (state_q != ENG_IDLE);
  assign mem_req  = (state_q == ENG_FETCH);
  assign mem_addr = addr_q;
  assign tvalid   = (state_q == ENG_SEND);
  assign tdata    = data_q;
  assign tlast    = (rem_q <= LW'(BPB));
  assign beat_ok  = tvalid && tready;
  assign done     = beat_ok && tlast;
  assign halt     = beat_ok && !tlast && !run;

  for (genvar i = 0; i < BPB; i++) begin : g_keep
    assign tkeep[i] = !tlast || (LW'(i) < rem_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      data_q  <= '0;
    end else begin
      case (state_q)
        ENG_IDLE: if (start) begin
          addr_q  <= src & ~AW'(BPB - 1);
          rem_q   <= len;
          state_q <= ENG_FETCH;
        end
        ENG_FETCH: if (mem_ack) begin
          data_q  <= mem_rdata;
          state_q <= ENG_SEND;
        end
        ENG_SEND: if (beat_ok) begin
          if (tlast || !run) begin
            state_q <= ENG_IDLE;
          end else begin
            addr_q  <= addr_q + AW'(BPB);
            rem_q   <= rem_q - LW'(BPB);
            state_q <= ENG_FETCH;
          end
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mm2s_dma_chan.sv
module mm2s_dma_chan #(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr_en,
  input  logic [1:0]      reg_wr_sel,
  input  logic [DW-1:0]   reg_wr_data,
  input  logic [1:0]      reg_rd_sel,
  output logic [DW-1:0]   reg_rd_data,
  output logic            irq,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  input  logic            mem_ack,
  input  logic [DW-1:0]   mem_rdata,
  output logic            m_tvalid,
  input  logic            m_tready,
  output logic [DW-1:0]   m_tdata,
  output logic [DW/8-1:0] m_tkeep,
  output logic            m_tlast
);
  logic          eng_busy, eng_done, eng_halt, run, start;
  logic [AW-1:0] src;
  logic [LW-1:0] start_len;

  dma_chan_regs #(.AW(AW), .LW(LW), .DW(DW)) u_regs (
    .clk, .rst_n,
    .wr_en(reg_wr_en), .wr_sel(reg_wr_sel), .wr_data(reg_wr_data),
    .rd_sel(reg_rd_sel), .rd_data(reg_rd_data),
    .eng_busy, .eng_done, .eng_halt,
    .run_o(run), .start_o(start), .src_o(src), .start_len_o(start_len),
    .irq_o(irq)
  );

  dma_chan_engine #(.AW(AW), .LW(LW), .DW(DW)) u_eng (
    .clk, .rst_n,
    .start, .src, .len(start_len), .run,
    .busy(eng_busy), .done(eng_done), .halt(eng_halt),
    .mem_req, .mem_addr, .mem_ack, .mem_rdata,
    .tvalid(m_tvalid), .tready(m_tready), .tdata(m_tdata),
    .tkeep(m_tkeep), .tlast(m_tlast)
  );
endmodule

// File: rtl/mm2s_dma_chan_chk.sv
module mm2s_dma_chan_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            eng_busy,
  input logic            mem_req,
  input logic [AW-1:0]   mem_addr,
  input logic            mem_ack,
  input logic            m_tvalid,
  input logic            m_tready,
  input logic [DW-1:0]   m_tdata,
  input logic [DW/8-1:0] m_tkeep,
  input logic            m_tlast
);
  localparam int BPB = DW / 8;

  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tkeep) && $stable(m_tlast)); // R4
  AST_KEEP_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> (m_tkeep != '0) && ((m_tkeep & (m_tkeep + 1'b1)) == '0)); // R3
  AST_FULL_UNLESS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tlast |-> &m_tkeep); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R10
  AST_NO_REQ_WITH_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && m_tvalid)); // R10
  AST_ALIGNED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr % BPB) == 0 && eng_busy); // R2
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && m_tready && m_tlast |=> !eng_busy); // R5
endmodule

bind mm2s_dma_chan mm2s_dma_chan_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .eng_busy(eng_busy),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
  .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
  .m_tkeep(m_tkeep), .m_tlast(m_tlast)
);

// File: tb/mm2s_dma_chan_test.sv
`timescale 1ns/1ps
module mm2s_dma_chan_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_wr_sel = '0;
  logic [31:0] reg_wr_data = '0;
  logic [1:0]  reg_rd_sel = '0;
  logic [31:0] reg_rd_data;
  logic        irq, mem_req, mem_ack = 1'b0, m_tvalid, m_tready = 1'b0, m_tlast;
  logic [31:0] mem_addr, mem_rdata = '0, m_tdata;
  logic [3:0]  m_tkeep;

  int checks = 0, failures = 0;
  bit finished = 0;
  bit rdy_mode = 0;
  logic [31:0] exp_wbase = '0;
  int exp_len = 0, beat_idx = 0;
  bit saw_last = 0;

  always #2 clk = ~clk;

  mm2s_dma_chan uut (.*);

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [3:0] exp_keep(input int rem);
    if (rem >= 4) return 4'hF;
    return 4'((1 << rem) - 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // stream sink, memory model and beat monitor
  logic        stall_q = 0, st_last = 0;
  logic [31:0] st_data = '0;
  logic [3:0]  st_keep = '0;
  initial begin
    forever begin
      @(negedge clk);
      if (stall_q)
        chk(m_tvalid && m_tdata == st_data && m_tkeep == st_keep && m_tlast == st_last,
            "R4 beat held under back-pressure", m_tdata, st_data);
      m_tready  = rdy_mode ? 1'b1 : ($urandom % 4 != 0);
      mem_ack   = ($urandom % 3 != 0);
      mem_rdata = mem_word(mem_addr);
      #1;
      stall_q = m_tvalid && !m_tready;
      st_data = m_tdata; st_keep = m_tkeep; st_last = m_tlast;
      if (m_tvalid && m_tready) begin
        int rem;
        rem = exp_len - beat_idx * 4;
        chk(m_tdata == mem_word(exp_wbase + 32'(beat_idx * 4)), "R2 beat data/address", m_tdata,
            mem_word(exp_wbase + 32'(beat_idx * 4)));
        chk(m_tkeep == exp_keep(rem), "R3 tkeep", 32'(m_tkeep), 32'(exp_keep(rem)));
        chk(m_tlast == (rem <= 4), "R3 tlast", 32'(m_tlast), 32'(rem <= 4));
        if (m_tlast) saw_last = 1;
        beat_idx++;
      end
    end
  end

  task automatic wreg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] sel, output logic [31:0] d);
    reg_rd_sel = sel;
    #1 d = reg_rd_data;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      rreg(2'd1, s);
      if (s[0]) break;
    end
    @(negedge clk);
  endtask

  task automatic arm(input logic [31:0] src, input int len, input bit mode);
    exp_wbase = src & ~32'd3; exp_len = len; beat_idx = 0; saw_last = 0; rdy_mode = mode;
    wreg(2'd2, src);
  endtask

  task automatic run_xfer(input logic [31:0] src, input int len, input bit mode);
    logic [31:0] s;
    arm(src, len, mode);
    wreg(2'd3, 32'(len));
    wait_idle();
    chk(beat_idx == (len + 3) / 4, "R2 beat count", 32'(beat_idx), 32'((len + 3) / 4));
    rreg(2'd1, s);
    chk(s[3:0] == 4'b0101, "R5 status after completion", s, 32'h5);
    wreg(2'd1, 32'hC);
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rreg(2'd1, v); chk(v == 32'h1, "R5 reset status", v, 32'h1);
    rreg(2'd0, v); chk(v == 32'h0, "R1 reset control", v, 32'h0);
    chk(!irq && !m_tvalid && !mem_req, "R7 reset outputs quiet", {irq, m_tvalid, mem_req}, 0);

    wreg(2'd2, 32'h1234_5678); rreg(2'd2, v); chk(v == 32'h1234_5678, "R1 source readback", v, 32'h1234_5678);
    wreg(2'd0, 32'h7); rreg(2'd0, v); chk(v == 32'h7, "R1 control readback", v, 32'h7);
    wreg(2'd0, 32'h1);

    // directed lengths covering each tail size
    run_xfer(32'h0000_1000, 1, 0);
    run_xfer(32'h0000_2002, 2, 0);
    run_xfer(32'h0000_3000, 3, 1);
    run_xfer(32'h0000_4000, 4, 0);
    run_xfer(32'h0000_5001, 5, 0);
    run_xfer(32'h0000_6000, 8, 1);
    rreg(2'd3, v); chk(v == 32'd8, "R1 length readback", v, 32'd8);
    for (int k = 0; k < 12; k++)
      run_xfer($urandom, 1 + int'($urandom % 64), bit'($urandom % 2));

    // completion interrupt and clearing
    wreg(2'd0, 32'h3);
    run_xfer(32'h0000_7000, 7, 0);
    wreg(2'd3, 32'd0); wreg(2'd1, 32'h8);
    arm(32'h0000_7100, 6, 0); wreg(2'd3, 32'd6); wait_idle();
    chk(irq == 1'b1, "R7 irq on completion", 32'(irq), 1);
    wreg(2'd1, 32'h4);
    rreg(2'd1, v); chk(v[2] == 1'b0, "R5 completion cleared by write-one", v, 32'h1);
    chk(irq == 1'b0, "R7 irq drops after clear", 32'(irq), 0);

    // error: run clear, then zero length
    wreg(2'd0, 32'h4);
    arm(32'h0000_8000, 8, 0); wreg(2'd3, 32'd8); repeat (10) @(negedge clk);
    chk(beat_idx == 0 && !mem_req, "R6 no transfer when stopped", 32'(beat_idx), 0);
    rreg(2'd1, v); chk(v[3:0] == 4'b1001, "R6 error flag when stopped", v, 32'h9);
    chk(irq == 1'b1, "R7 irq on error", 32'(irq), 1);
    wreg(2'd0, 32'h1); chk(irq == 1'b0, "R7 error irq masked", 32'(irq), 0);
    wreg(2'd1, 32'h8);
    wreg(2'd3, 32'd0); repeat (10) @(negedge clk);
    chk(beat_idx == 0, "R6 no transfer for zero length", 32'(beat_idx), 0);
    rreg(2'd1, v); chk(v[3:0] == 4'b1001, "R6 error flag for zero length", v, 32'h9);
    wreg(2'd1, 32'h8);

    // length write while busy is ignored
    arm(32'h0000_9000, 64, 0); wreg(2'd3, 32'd64);
    repeat (5) @(negedge clk);
    wreg(2'd3, 32'd8);
    rreg(2'd3, v); chk(v == 32'd64, "R9 length unchanged while busy", v, 32'd64);
    wait_idle();
    chk(beat_idx == 16, "R9 transfer unaffected", 32'(beat_idx), 16);
    rreg(2'd1, v); chk(v[3:0] == 4'b0101, "R9 no error from busy write", v, 32'h5);
    wreg(2'd1, 32'hC);

    // halt mid-transfer
    arm(32'h0000_A000, 400, 1); wreg(2'd3, 32'd400);
    repeat (20) @(negedge clk);
    wreg(2'd0, 32'h0);
    wait_idle();
    repeat (10) @(negedge clk);
    chk(beat_idx > 0 && beat_idx < 100 && !saw_last, "R8 stopped early without last", 32'(beat_idx), 100);
    rreg(2'd1, v); chk(v[3:0] == 4'b0011, "R8 halted flag", v, 32'h3);
    wreg(2'd0, 32'h1);
    run_xfer(32'h0000_B000, 4, 0);
    rreg(2'd1, v); chk(v[1] == 1'b0, "R8 halted cleared by restart", v, 32'h1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule